// File: doc/BRIEF.md
# Circular Code-Read DMA Controller

This block keeps a small on-chip queue of 32-bit doublewords topped up from a contiguous region of host memory that holds compressed code. Whenever the queue level drops below a programmable threshold and reading is enabled, it raises a read-burst request carrying a start address and a length in doublewords. A request/grant/data handshake stands in for the system bus. Returned beats are written into the queue, and a downstream consumer pops them in order.

The read position is kept as a byte offset from a programmable base. When it reaches the end of the region, it either wraps back to the base and keeps going, or halts until software writes a new base. Clearing the enable pauses the pointer where it is, and setting it again continues from that point. Every time the transferred byte count reaches a programmable step, a one-cycle progress pulse fires and the current offset within the region is latched for software. The region size and the step are 3-bit codes. Codes outside the defined range fall back to fixed defaults.

FSM states: `ST_IDLE` (evaluate the end of region and the refill condition), `ST_REQ` (request raised, waiting for grant), `ST_DATA` (collecting beats), `ST_HALT` (end reached without wrap).

The transitions are:
- IDLE→REQ when a refill is wanted.
- IDLE→IDLE with the offset reloaded to zero when the end is reached with wrap on.
- IDLE→HALT when the end is reached with wrap off.
- REQ→DATA on grant.
- DATA→IDLE on the last beat.
- HALT→IDLE on a base write.

Top module: `code_ring_reader`

## Requirements
- R1: The control word has this layout: bits 2:0 size code, 5:3 step code, 8:6 threshold, 9 read enable, 10 wrap enable, 11 flush. It resets to 0x98B, which is size code 3, step code 1, threshold 6, read enable 0, wrap 0 and flush 1. Out of reset the queue reads empty and no request is raised.
- R2: Size codes 0 to 5 select regions of 8, 16, 32, 64, 128 and 256 KB. Codes 6 and 7 select 64 KB.
- R3: Step codes 0 to 5 select 8, 16, 32, 64, 128 and 256 KB, and codes 6 and 7 select 16 KB. Each time the transferred byte count since the last base write reaches another step, `irq_pulse` is high for exactly one cycle, in the cycle after the beat that completes the step. `irq_offset` then holds the offset of the next byte to fetch, taken modulo the region size.
- R4: A request is raised only when all of these hold: read enable is 1, flush is 0, and the queue level is below the threshold. A threshold of 0 therefore never requests.
- R5: While read enable is 0, no new request is raised and the offset holds its value. After read enable returns to 1, the next request starts at base plus the held offset.
- R6: When the offset reaches the region size and wrap is 1, the next request starts at the base. When wrap is 0, no further request is raised until the base is written.
- R7: While flush is 1, the queue is emptied, data beats are discarded and no request is raised. After flush returns to 0, the queue starts empty.
- R8: A burst length is at least 1 and at most `BURST_DW`, never exceeds the free queue space, and never runs past base plus region size.
- R9: The consumer sees the fetched doublewords in address order. `fifo_empty` is 1 exactly when the queue holds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 12 | New control word (layout in R1) |
| ctrl_rdata | output | 12 | Current control word |
| base_wr | input | 1 | Write strobe for the base; clears offset and step count |
| base_wdata | input | ADDR_W | New region base address |
| req_valid | output | 1 | Burst request pending |
| req_addr | output | ADDR_W | Burst start byte address |
| req_len | output | LEN_W | Burst length in doublewords |
| req_grant | input | 1 | Request accepted; beats follow |
| beat_valid | input | 1 | One returned doubleword |
| beat_data | input | DATA_W | Returned doubleword |
| pop | input | 1 | Consumer takes the head entry |
| out_data | output | DATA_W | Head entry of the queue |
| fifo_empty | output | 1 | Queue holds no data |
| fifo_level | output | CW | Queue level in doublewords |
| irq_pulse | output | 1 | Progress pulse |
| irq_offset | output | OFS_W | Offset latched at the last progress pulse |

## Verification
On every cycle, the checker confirms the following:
- A request only rises after a cycle in which the threshold, enable and flush conditions held.
- An active burst fits inside the region.
- The queue never overfills.
- The queue is empty one edge after flush.
- The pointer is frozen while paused in idle.
- The progress pulse never lasts two cycles.
- No request appears past the end with wrap off.

Only the bench scenarios can show the following:
- The right start address after a wrap or a resume.
- The exact offsets reported at each step under the fallback codes.
- The in-order data delivered to the consumer.
- The decoded region sizes as seen through where wrapping and halting occur.

// File: rtl/crr_pkg.sv
package crr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2,
        ST_HALT = 2'd3
    } crr_state_e;

    typedef struct packed {
        logic       flush;
        logic       wrap_en;
        logic       read_en;
        logic [2:0] thresh;
        logic [2:0] step_code;
        logic [2:0] size_code;
    } crr_ctrl_t;

    localparam crr_ctrl_t CTRL_RESET = '{
        flush:     1'b1,
        wrap_en:   1'b0,
        read_en:   1'b0,
        thresh:    3'd6,
        step_code: 3'd1,
        size_code: 3'd3
    };

endpackage

// File: rtl/crr_scale_decode.sv
module crr_scale_decode #(
    parameter int          UNIT_BYTES = 8192,
    parameter int          OFS_W      = 19,
    parameter logic [2:0]  FALLBACK   = 3'd3
) (
    input  logic [2:0]       code,
    output logic [OFS_W-1:0] bytes
);
    logic [2:0]       idx;
    logic [OFS_W-1:0] unit_v;

    assign unit_v = OFS_W'(UNIT_BYTES);
    assign idx    = (code > 3'd5) ? FALLBACK : code;
    assign bytes  = unit_v << idx;
endmodule

// File: rtl/crr_fifo.sv
module crr_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CW-1:0]     level,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              do_push, do_pop;

    assign do_push = push && !flush && (level < CW'(DEPTH));
    assign do_pop  = pop && !flush && (level != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            if (do_push && !do_pop)      level <= level + CW'(1);
            else if (do_pop && !do_push) level <= level - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    assign rdata = mem[rp];
    assign empty = (level == '0);
endmodule

// File: rtl/crr_progress.sv
module crr_progress #(
    parameter int OFS_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             beat,
    input  logic [OFS_W-1:0] step_bytes,
    input  logic [OFS_W-1:0] pos_in,
    output logic             irq,
    output logic [OFS_W-1:0] pos_out
);
    logic [OFS_W-1:0] acc, acc_nxt;

    assign acc_nxt = acc + OFS_W'(4);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            irq     <= 1'b0;
            pos_out <= '0;
        end else if (clear) begin
            acc <= '0;
            irq <= 1'b0;
        end else if (beat) begin
            if (acc_nxt >= step_bytes) begin
                acc     <= '0;
                irq     <= 1'b1;
                pos_out <= pos_in;
            end else begin
                acc <= acc_nxt;
                irq <= 1'b0;
            end
        end else begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/code_ring_reader.sv
module code_ring_reader #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 8,
    parameter int BURST_DW   = 4,
    parameter int UNIT_BYTES = 8192,
    localparam int OFS_W     = $clog2(UNIT_BYTES * 32) + 1,
    localparam int CW        = $clog2(DEPTH + 1),
    localparam int LEN_W     = $clog2(BURST_DW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [11:0]       ctrl_wdata,
    output logic [11:0]       ctrl_rdata,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    input  logic              req_grant,
    input  logic              beat_valid,
    input  logic [DATA_W-1:0] beat_data,
    input  logic              pop,
    output logic [DATA_W-1:0] out_data,
    output logic              fifo_empty,
    output logic [CW-1:0]     fifo_level,
    output logic              irq_pulse,
    output logic [OFS_W-1:0]  irq_offset
);
    import crr_pkg::*;

    crr_ctrl_t         ctrl_q;
    crr_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [LEN_W-1:0]  len_q;
    logic [OFS_W-1:0]  size_bytes, step_bytes;
    logic [OFS_W-1:0]  rem_dw, cand, ofs_inc, pos_next;
    logic [CW-1:0]     free_dw;
    logic [LEN_W-1:0]  len_next;
    logic              at_end, want, beat;

    crr_scale_decode #(.UNIT_BYTES(UNIT_BYTES), .OFS_W(OFS_W), .FALLBACK(3'd3))
        u_size (.code(ctrl_q.size_code), .bytes(size_bytes));
    crr_scale_decode #(.UNIT_BYTES(UNIT_BYTES), .OFS_W(OFS_W), .FALLBACK(3'd1))
        u_step (.code(ctrl_q.step_code), .bytes(step_bytes));

    assign at_end  = (ofs_q >= size_bytes);
    assign rem_dw  = at_end ? '0 : ((size_bytes - ofs_q) >> 2);
    assign free_dw = CW'(DEPTH) - fifo_level;

    always_comb begin
        cand = OFS_W'(BURST_DW);
        if (OFS_W'(free_dw) < cand) cand = OFS_W'(free_dw);
        if (rem_dw < cand)          cand = rem_dw;
        len_next = LEN_W'(cand);
    end

    assign want = ctrl_q.read_en && !ctrl_q.flush
               && (32'(fifo_level) < 32'(ctrl_q.thresh))
               && (len_next != '0);
    assign beat     = beat_valid && (state_q == ST_DATA);
    assign ofs_inc  = ofs_q + OFS_W'(4);
    assign pos_next = (ofs_inc >= size_bytes) ? '0 : ofs_inc;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (at_end)     state_d = ctrl_q.wrap_en ? ST_IDLE : ST_HALT;
                else if (want)  state_d = ST_REQ;
            end
            ST_REQ:  if (req_grant) state_d = ST_DATA;
            ST_DATA: if (beat && len_q == LEN_W'(1)) state_d = ST_IDLE;
            ST_HALT: if (base_wr) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registers, pointer and burst counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            base_q <= '0;
            ofs_q  <= '0;
            len_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= crr_ctrl_t'(ctrl_wdata);
            if (base_wr) begin
                base_q <= base_wdata;
                ofs_q  <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (at_end && ctrl_q.wrap_en) ofs_q <= '0;
                        else if (!at_end && want)     len_q <= len_next;
                    end
                    ST_DATA: begin
                        if (beat) begin
                            ofs_q <= ofs_inc;
                            len_q <= len_q - LEN_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        req_valid  = (state_q == ST_REQ);
        req_addr   = base_q + ADDR_W'(ofs_q);
        req_len    = len_q;
        ctrl_rdata = ctrl_q;
    end

    crr_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (ctrl_q.flush),
        .push  (beat),
        .wdata (beat_data),
        .pop   (pop),
        .rdata (out_data),
        .level (fifo_level),
        .empty (fifo_empty)
    );

    crr_progress #(.OFS_W(OFS_W)) u_prog (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (base_wr),
        .beat       (beat),
        .step_bytes (step_bytes),
        .pos_in     (pos_next),
        .irq        (irq_pulse),
        .pos_out    (irq_offset)
    );
endmodule

// File: rtl/crr_checker.sv
module crr_checker #(
    parameter int DEPTH = 8,
    parameter int OFS_W = 19,
    parameter int CW    = 4,
    parameter int LEN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic [CW-1:0]    level,
    input logic             fifo_empty,
    input logic [2:0]       thresh,
    input logic             read_en,
    input logic             flush,
    input logic             wrap_en,
    input logic [OFS_W-1:0] ofs,
    input logic [OFS_W-1:0] size_bytes,
    input logic             in_idle,
    input logic             base_wr,
    input logic             irq_pulse
);
    logic [OFS_W:0] burst_end;
    assign burst_end = {1'b0, ofs} + (OFS_W+1)'({req_len, 2'b00});

    // R4: request rises only after a cycle meeting enable, flush and level
    a_r4_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(read_en && !flush && (32'(level) < 32'(thresh))));

    // R8: pending burst is non-empty and ends inside the region
    a_r8_burst_fits: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0 && burst_end <= {1'b0, size_bytes}));

    // R8: the queue never holds more than its depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        32'(level) <= DEPTH);

    // R7: one edge after flush is seen, the queue is empty
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> fifo_empty);

    // R5: paused in idle, the pointer does not move
    a_r5_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!read_en && in_idle && !base_wr && ofs < size_bytes) |=> $stable(ofs));

    // R3: progress pulse lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R6: at the end with wrap off, no request
    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs >= size_bytes && !wrap_en) |-> !req_valid);
endmodule

bind code_ring_reader crr_checker #(
    .DEPTH(DEPTH), .OFS_W(OFS_W), .CW(CW), .LEN_W(LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .level      (fifo_level),
    .fifo_empty (fifo_empty),
    .thresh     (ctrl_q.thresh),
    .read_en    (ctrl_q.read_en),
    .flush      (ctrl_q.flush),
    .wrap_en    (ctrl_q.wrap_en),
    .ofs        (ofs_q),
    .size_bytes (size_bytes),
    .in_idle    (state_q == crr_pkg::ST_IDLE),
    .base_wr    (base_wr),
    .irq_pulse  (irq_pulse)
);

// File: tb/tb_code_ring_reader.sv
module tb_code_ring_reader;
    localparam int ADDR_W = 32, DATA_W = 32, DEPTH = 8, BURST_DW = 4;
    localparam int OFS_W = 19, CW = 4, LEN_W = 3;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              ctrl_wr = 1'b0, base_wr = 1'b0;
    logic [11:0]       ctrl_wdata = '0, ctrl_rdata;
    logic [ADDR_W-1:0] base_wdata = '0, req_addr;
    logic              req_valid, req_grant = 1'b0;
    logic [LEN_W-1:0]  req_len;
    logic              beat_valid = 1'b0, pop = 1'b0;
    logic [DATA_W-1:0] beat_data = '0, out_data;
    logic              fifo_empty, irq_pulse;
    logic [CW-1:0]     fifo_level;
    logic [OFS_W-1:0]  irq_offset;

    code_ring_reader dut (.*);

    always #4 clk = ~clk;

    int checks = 0, fails = 0;
    // bench model
    logic [31:0] base_m = '0;
    int size_m = 65536, step_m = 16384, ofs_m = 0, acc_m = 0;
    bit wrap_m = 0, flush_m = 1, exp_irq = 0, started = 0, busy = 0, cons_en = 0;
    int exp_pos = 0, irq_cnt = 0, reqs_seen = 0, last_irq_pos = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] q[$];
    int cur_sz = 3, cur_st = 1, cur_thr = 6;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int size_of(input int c);
        return 8192 << ((c > 5) ? 3 : c);
    endfunction
    function automatic int step_of(input int c);
        return 8192 << ((c > 5) ? 1 : c);
    endfunction

    task automatic write_ctrl(input int sz, input int st, input int thr, input bit rd, input bit wr, input bit fl);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = {fl, wr, rd, 3'(thr), 3'(st), 3'(sz)};
        size_m = size_of(sz); step_m = step_of(st); wrap_m = wr;
        cur_sz = sz; cur_st = st; cur_thr = thr;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic write_base(input logic [31:0] b);
        @(negedge clk);
        base_wr = 1'b1; base_wdata = b;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    task automatic wait_quiet();
        do @(negedge clk); while (busy || req_valid);
        repeat (3) @(negedge clk);
    endtask

    // model update on the same edges the design uses
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); flush_m = 1; exp_irq = 0;
        end else begin
            exp_irq = 0;
            if (flush_m) q.delete();
            else begin
                if (pop && q.size() > 0) void'(q.pop_front());
                if (beat_valid) q.push_back(beat_data);
            end
            if (beat_valid) begin
                ofs_m += 4; acc_m += 4;
                if (acc_m >= step_m) begin
                    exp_irq = 1; acc_m = 0;
                    exp_pos = (ofs_m >= size_m) ? 0 : ofs_m;
                end
            end
            if (ctrl_wr) flush_m = ctrl_wdata[11];
            if (base_wr) begin base_m = base_wdata; ofs_m = 0; acc_m = 0; end
        end
    end

    // checker of outputs and consumer, away from the edge
    initial begin
        forever begin
            @(negedge clk);
            if (started) begin
                chk(irq_pulse == exp_irq, "R3 pulse", 64'(irq_pulse), 64'(exp_irq));
                if (exp_irq) begin
                    chk(irq_offset == OFS_W'(exp_pos), "R3 offset", 64'(irq_offset), 64'(exp_pos));
                    irq_cnt++; last_irq_pos = int'(irq_offset);
                end
                chk(fifo_empty == (q.size() == 0), "R9 empty", 64'(fifo_empty), 64'(q.size() == 0));
                if (!fifo_empty && q.size() > 0)
                    chk(out_data == q[0], "R9 order", 64'(out_data), 64'(q[0]));
            end
            pop = cons_en && !fifo_empty && ($urandom % 2 == 0);
        end
    end

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (req_valid) begin
                logic [31:0] a;
                int l;
                busy = 1; a = req_addr; l = int'(req_len);
                reqs_seen++; last_addr = a;
                if (wrap_m && ofs_m >= size_m) ofs_m = 0;
                chk(a == base_m + 32'(ofs_m), "R6/R5 start address", 64'(a), 64'(base_m + 32'(ofs_m)));
                chk(l >= 1 && l <= BURST_DW && ofs_m + 4 * l <= size_m, "R8 burst length",
                    64'(l), 64'((size_m - ofs_m) / 4));
                repeat ($urandom % 3) @(negedge clk);
                req_grant = 1'b1;
                @(negedge clk);
                req_grant = 1'b0;
                for (int i = 0; i < l; i++) begin
                    repeat ($urandom % 2) @(negedge clk);
                    beat_valid = 1'b1; beat_data = a + 32'(4 * i);
                    @(negedge clk);
                    beat_valid = 1'b0;
                end
                busy = 0;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed_v, n0, sv;
        seed_v = $urandom(32'hC0DE);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctrl_rdata == 12'h98B, "R1 control reset", 64'(ctrl_rdata), 64'h98B);
        chk(fifo_empty == 1'b1, "R1 empty at reset", 64'(fifo_empty), 1);
        begin
            bit seen = 0;
            repeat (20) begin @(negedge clk); if (req_valid) seen = 1; end
            chk(!seen, "R1 no request after reset", 64'(seen), 0);
        end
        started = 1;

        // R4 threshold 0 never requests
        write_base(32'h1000_0000);
        write_ctrl(1, 0, 0, 1, 1, 0);
        repeat (60) @(negedge clk);
        chk(reqs_seen == 0, "R4 threshold zero", 64'(reqs_seen), 0);

        // R6 ring run, 16 KB region, 8 KB step, R2 size code 1
        cons_en = 1;
        write_ctrl(1, 0, 6, 1, 1, 0);
        wait (irq_cnt >= 3);
        chk(last_irq_pos == 8192, "R2 R6 wrap position", 64'(last_irq_pos), 8192);

        // R5 pause and resume
        write_ctrl(1, 0, 6, 0, 1, 0);
        wait_quiet();
        sv = ofs_m; n0 = reqs_seen;
        repeat (100) @(negedge clk);
        chk(reqs_seen == n0, "R5 no request while paused", 64'(reqs_seen), 64'(n0));
        chk(ofs_m == sv, "R5 pointer held", 64'(ofs_m), 64'(sv));
        write_ctrl(1, 0, 6, 1, 1, 0);
        wait (reqs_seen > n0);
        @(negedge clk);
        chk(last_addr == base_m + 32'((sv >= size_m) ? 0 : sv), "R5 resume address",
            64'(last_addr), 64'(base_m + 32'(sv)));

        // R4 stops refill at threshold, R7 flush
        cons_en = 0;
        repeat (200) @(negedge clk);
        wait_quiet();
        chk(32'(fifo_level) >= 6, "R4 level at threshold", 64'(fifo_level), 6);
        n0 = reqs_seen;
        repeat (80) @(negedge clk);
        chk(reqs_seen == n0, "R4 no refill above threshold", 64'(reqs_seen), 64'(n0));
        write_ctrl(1, 0, 6, 1, 1, 1);
        @(negedge clk);
        chk(fifo_empty == 1'b1, "R7 flushed", 64'(fifo_empty), 1);
        n0 = reqs_seen;
        repeat (80) @(negedge clk);
        chk(reqs_seen == n0, "R7 no request during flush", 64'(reqs_seen), 64'(n0));
        write_ctrl(1, 0, 6, 0, 1, 0);
        @(negedge clk);
        chk(fifo_empty == 1'b1, "R7 empty after flush", 64'(fifo_empty), 1);

        // R6 hard stop, 8 KB region
        cons_en = 1;
        write_base(32'h2000_0000);
        write_ctrl(0, 0, 6, 1, 0, 0);
        wait (ofs_m >= 8192);
        wait_quiet();
        n0 = reqs_seen;
        repeat (300) @(negedge clk);
        chk(reqs_seen == n0, "R6 halted at end", 64'(reqs_seen), 64'(n0));
        chk(ofs_m == 8192, "R6 bytes moved", 64'(ofs_m), 8192);

        // R2 R3 fallback codes: 64 KB region, 16 KB step
        write_ctrl(0, 0, 6, 0, 0, 0);
        write_base(32'h3000_0000);
        write_ctrl(7, 6, 6, 1, 1, 0);
        chk(ctrl_rdata == 12'h7B7, "R1 control readback", 64'(ctrl_rdata), 64'h7B7);
        n0 = irq_cnt;
        wait (irq_cnt >= n0 + 1);
        @(negedge clk);
        chk(last_irq_pos == 16384, "R3 fallback step", 64'(last_irq_pos), 16384);
        wait (irq_cnt >= n0 + 4);
        @(negedge clk);
        chk(last_irq_pos == 0, "R2 fallback size wrap", 64'(last_irq_pos), 0);

        // random mix
        for (int it = 0; it < 4; it++) begin
            int sz, st, th;
            sz = $urandom % 8; st = $urandom % 8; th = 1 + $urandom % 7;
            if (step_of(st) > size_of(sz)) st = 0;
            write_ctrl(cur_sz, cur_st, cur_thr, 0, 1, 0);
            wait_quiet();
            write_base(32'h4000_0000 + 32'(it) * 32'h0010_0000);
            write_ctrl(sz, st, th, 1, 1, 0);
            repeat (2500) @(negedge clk);
        end
        write_ctrl(cur_sz, cur_st, cur_thr, 0, 1, 0);
        wait_quiet();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule